// File: doc/BRIEF.md
# Raster Scan Height Regulator

This block walks a probe across a rectangular grid of sample sites, one site at a time, and at each site regulates the probe's vertical actuator. The regulation is a proportional-plus-integral loop. It drives a measured interaction value toward a target level. The block takes one signed interaction sample per `sampleValid` strobe. It returns the grid position to the lateral drive and an actuator code to the vertical drive. For each grid site it also emits one record that carries the height and a second data channel.

A frame has two modes. In feedback mode, the second data channel holds the residual error of the loop. In fixed-height mode, the actuator code stays frozen for the whole frame and the second data channel holds the raw interaction value. Fixed-height mode also waits out a settling window at the start of the frame and after every move to a new row.

Several settings are captured when `start` is accepted and stay fixed for the frame: the mode, target level, grid size, dwell count and settling length. The gains and the actuator limits are used live.

Top module: `scan_zloop`

## Requirements
- R1: After reset, `busy`, `recValid` and `frameDone` are 0, `zOut` is 0, and `posX` and `posY` are 0.
- R2: Sites are visited with X rising from 0 to `gridX-1`. After the last column, X returns to 0 and Y rises by one. `posX`/`posY` always show the site that is currently being sampled.
- R3: In feedback mode, each accepted sample works as follows. The error is err = target − sample. The integrator gains `ki`·err. `zOut` becomes (integrator + `kp`·err) shifted arithmetically right by 4, and this value shows on the next clock edge.
- R4: The integrator saturates at +(2^(IW-1)−1) and at −2^(IW-1), and never wraps. IW is 20 by default.
- R5: In feedback mode, every updated `zOut` is limited to the range [`zMin`, `zMax`].
- R6: A site's record is taken on the `dwell`-th accepted sample at that site. `recValid` pulses for one cycle with `recX`/`recY` set to that site. In feedback mode, `recZ` equals the newly computed `zOut` and `recData` equals err.
- R7: With `heightMode`=1 captured at start, `zOut` does not change during the frame. `recZ` is the held code, and `recData` is the sample, sign-extended.
- R8: In fixed-height mode, samples are ignored during the `settleCycles`+1 cycles that follow the accepted start, and during the same interval after each row advance.
- R9: `frameDone` pulses for one cycle together with the record of the last site. In that same cycle `busy` is already 0.
- R10: Changes to `heightMode` or `setpoint` made during a frame have no effect before the next start.
- R11: A `start` pulse while `busy` is 1 is ignored, and the scan position continues unchanged.
- R12: While idle, `sampleValid` has no effect on `zOut` or on the record outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (accepted only while idle) |
| heightMode | input | 1 | 1 = fixed-height, 0 = feedback; captured at start |
| setpoint | input | DW | Signed target interaction level; captured at start |
| kp | input | GW | Unsigned proportional gain |
| ki | input | GW | Unsigned integral gain |
| zMin | input | ZW | Lower actuator limit |
| zMax | input | ZW | Upper actuator limit |
| gridX | input | CW | Columns per row (at least 1) |
| gridY | input | CW | Rows per frame (at least 1) |
| dwell | input | DWELLW | Samples per site (at least 1) |
| settleCycles | input | SETTLEW | Settling length in fixed-height mode |
| sampleValid | input | 1 | Sample strobe |
| sampleIn | input | DW | Signed interaction sample |
| posX | output | CW | Current column |
| posY | output | CW | Current row |
| zOut | output | ZW | Vertical actuator code |
| busy | output | 1 | Frame in progress |
| recValid | output | 1 | Site record strobe |
| recX | output | CW | Column of the record |
| recY | output | CW | Row of the record |
| recZ | output | ZW | Recorded height |
| recData | output | DW+1 | Error (feedback) or raw sample (fixed-height) |
| frameDone | output | 1 | Last site recorded |

## Verification
Every sample accepted on a clock edge updates `zOut` on that same edge. When the sample completes a site, the record strobe and its fields, along with `frameDone` for the final site, also appear on that edge, so all results are due one cycle after the strobe. The bench drives each strobe at a falling edge and reads back every result at the next falling edge, when the register stage has settled. For the settling window, the bench counts edges from the accepted start or row advance. It places ignored strobes inside that window and accepted strobes after it.

// File: rtl/scan_zloop_pkg.sv
package scan_zloop_pkg;
  typedef struct packed {
    logic frameStart;
    logic take;
    logic last;
    logic holdZ;
  } zstrobe_t;
endpackage

// File: rtl/scan_zloop_ctrl.sv
module scan_zloop_ctrl
  import scan_zloop_pkg::*;
#(
  parameter int CW      = 8,
  parameter int DWELLW  = 8,
  parameter int SETTLEW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               heightMode,
  input  logic               sampleValid,
  input  logic [CW-1:0]      gridX,
  input  logic [CW-1:0]      gridY,
  input  logic [DWELLW-1:0]  dwell,
  input  logic [SETTLEW-1:0] settleCycles,
  output zstrobe_t           st,
  output logic [CW-1:0]      posX,
  output logic [CW-1:0]      posY,
  output logic               recValid,
  output logic [CW-1:0]      recX,
  output logic [CW-1:0]      recY,
  output logic               frameDone,
  output logic               busy
);
  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_DWELL} state_t;

  state_t             state;
  logic               modeQ;
  logic [CW-1:0]      gxQ, gyQ;
  logic [DWELLW-1:0]  dwQ, dcnt;
  logic [SETTLEW-1:0] settleQ, cnt;

  always_comb begin
    st.frameStart = (state == S_IDLE) && start;
    st.take       = (state == S_DWELL) && sampleValid;
    st.last       = st.take && (dcnt == dwQ - DWELLW'(1));
    st.holdZ      = modeQ;
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      modeQ     <= 1'b0;
      gxQ       <= '0;
      gyQ       <= '0;
      dwQ       <= '0;
      dcnt      <= '0;
      settleQ   <= '0;
      cnt       <= '0;
      posX      <= '0;
      posY      <= '0;
      recValid  <= 1'b0;
      recX      <= '0;
      recY      <= '0;
      frameDone <= 1'b0;
    end else begin
      recValid  <= 1'b0;
      frameDone <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          modeQ   <= heightMode;
          gxQ     <= gridX;
          gyQ     <= gridY;
          dwQ     <= dwell;
          settleQ <= settleCycles;
          cnt     <= settleCycles;
          dcnt    <= '0;
          posX    <= '0;
          posY    <= '0;
          state   <= heightMode ? S_SETTLE : S_DWELL;
        end
        S_SETTLE: begin
          if (cnt == '0) state <= S_DWELL;
          else           cnt   <= cnt - SETTLEW'(1);
        end
        S_DWELL: if (st.take) begin
          if (st.last) begin
            dcnt     <= '0;
            recValid <= 1'b1;
            recX     <= posX;
            recY     <= posY;
            if (posX == gxQ - CW'(1)) begin
              posX <= '0;
              if (posY == gyQ - CW'(1)) begin
                frameDone <= 1'b1;
                state     <= S_IDLE;
              end else begin
                posY <= posY + CW'(1);
                if (modeQ) begin
                  cnt   <= settleQ;
                  state <= S_SETTLE;
                end
              end
            end else begin
              posX <= posX + CW'(1);
            end
          end else begin
            dcnt <= dcnt + DWELLW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: the final record leaves the block idle in the same cycle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> (!busy && recValid));

  // R2: the position stays inside the captured grid while scanning
  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != S_IDLE) |-> (posX < gxQ && posY < gyQ));

  // R8: a strobe during settling neither records nor moves the probe
  p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETTLE && sampleValid) |=> (!recValid && $stable(posX) && $stable(posY)));

  // R11: a start while busy does not send the scan back to the origin
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !st.take) |=> ($stable(posX) && $stable(posY)));
endmodule

// File: rtl/scan_zloop_dp.sv
module scan_zloop_dp
  import scan_zloop_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GW    = 8,
  parameter int ZW    = 16,
  parameter int IW    = 20,
  parameter int SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  zstrobe_t             st,
  input  logic signed [DW-1:0] sampleIn,
  input  logic signed [DW-1:0] setpoint,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic [ZW-1:0]        zMin,
  input  logic [ZW-1:0]        zMax,
  output logic [ZW-1:0]        zOut,
  output logic [ZW-1:0]        recZ,
  output logic signed [DW:0]   recData
);
  localparam int EW  = DW + 1;
  localparam int PW  = EW + GW + 1;
  localparam int WA  = (IW > PW) ? IW : PW;
  localparam int WW  = (WA > ZW ? WA : ZW) + 2;
  localparam logic signed [WW-1:0] IMAX = WW'((64'sd1 <<< (IW-1)) - 64'sd1);
  localparam logic signed [WW-1:0] IMIN = WW'(-(64'sd1 <<< (IW-1)));

  logic signed [DW-1:0] spQ;
  logic signed [IW-1:0] integ;
  logic signed [EW-1:0] err, sampleExt;
  logic signed [WW-1:0] errW, kpW, kiW, iSum, iNext, zRaw, zMinW, zMaxW;
  logic [ZW-1:0]        zNext;

  always_comb begin
    sampleExt = {sampleIn[DW-1], sampleIn};
    err       = {spQ[DW-1], spQ} - sampleExt;
    errW      = WW'(err);
    kpW       = $signed(WW'({1'b0, kp}));
    kiW       = $signed(WW'({1'b0, ki}));
    iSum      = WW'(integ) + errW * kiW;
    if (iSum > IMAX)      iNext = IMAX;
    else if (iSum < IMIN) iNext = IMIN;
    else                  iNext = iSum;
    zRaw  = (iNext + errW * kpW) >>> SHIFT;
    zMinW = $signed(WW'({1'b0, zMin}));
    zMaxW = $signed(WW'({1'b0, zMax}));
    if (zRaw < zMinW)      zNext = zMin;
    else if (zRaw > zMaxW) zNext = zMax;
    else                   zNext = zRaw[ZW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spQ     <= '0;
      integ   <= '0;
      zOut    <= '0;
      recZ    <= '0;
      recData <= '0;
    end else begin
      if (st.frameStart) spQ <= setpoint;
      if (st.take && !st.holdZ) begin
        integ <= iNext[IW-1:0];
        zOut  <= zNext;
      end
      if (st.last) begin
        recZ    <= st.holdZ ? zOut : zNext;
        recData <= st.holdZ ? sampleExt : err;
      end
    end
  end

  // R5: each feedback update lands inside the actuator limits
  p_z_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st.take && !st.holdZ && zMin <= zMax) |=>
      (zOut >= $past(zMin) && zOut <= $past(zMax)));

  // R7: fixed-height samples leave the actuator code untouched
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st.take && st.holdZ) |=> $stable(zOut));

  // R12: with no accepted sample the actuator code does not move
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !st.take |=> $stable(zOut));
endmodule

// File: rtl/scan_zloop.sv
module scan_zloop
  import scan_zloop_pkg::*;
#(
  parameter int DW      = 16,
  parameter int GW      = 8,
  parameter int ZW      = 16,
  parameter int IW      = 20,
  parameter int SHIFT   = 4,
  parameter int CW      = 8,
  parameter int DWELLW  = 8,
  parameter int SETTLEW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 heightMode,
  input  logic signed [DW-1:0] setpoint,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic [ZW-1:0]        zMin,
  input  logic [ZW-1:0]        zMax,
  input  logic [CW-1:0]        gridX,
  input  logic [CW-1:0]        gridY,
  input  logic [DWELLW-1:0]    dwell,
  input  logic [SETTLEW-1:0]   settleCycles,
  input  logic                 sampleValid,
  input  logic signed [DW-1:0] sampleIn,
  output logic [CW-1:0]        posX,
  output logic [CW-1:0]        posY,
  output logic [ZW-1:0]        zOut,
  output logic                 busy,
  output logic                 recValid,
  output logic [CW-1:0]        recX,
  output logic [CW-1:0]        recY,
  output logic [ZW-1:0]        recZ,
  output logic signed [DW:0]   recData,
  output logic                 frameDone
);
  zstrobe_t st;

  scan_zloop_ctrl #(.CW(CW), .DWELLW(DWELLW), .SETTLEW(SETTLEW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .heightMode(heightMode),
    .sampleValid(sampleValid), .gridX(gridX), .gridY(gridY), .dwell(dwell),
    .settleCycles(settleCycles), .st(st), .posX(posX), .posY(posY),
    .recValid(recValid), .recX(recX), .recY(recY), .frameDone(frameDone),
    .busy(busy)
  );

  scan_zloop_dp #(.DW(DW), .GW(GW), .ZW(ZW), .IW(IW), .SHIFT(SHIFT)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .sampleIn(sampleIn),
    .setpoint(setpoint), .kp(kp), .ki(ki), .zMin(zMin), .zMax(zMax),
    .zOut(zOut), .recZ(recZ), .recData(recData)
  );
endmodule

// File: tb/scan_zloop_bench.sv
module scan_zloop_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, heightMode = 1'b0, sampleValid = 1'b0;
  logic signed [15:0] setpoint = '0, sampleIn = '0;
  logic [7:0]  kp = '0, ki = '0, gridX = 8'd1, gridY = 8'd1, dwell = 8'd1;
  logic [15:0] zMin = '0, zMax = 16'hFFFF, settleCycles = '0;
  logic [7:0]  posX, posY, recX, recY;
  logic [15:0] zOut, recZ;
  logic signed [16:0] recData;
  logic busy, recValid, frameDone;

  int checks = 0, errors = 0;
  int integM = 0, zM = 0, spM = 0, kpM = 0, kiM = 0, zLo = 0, zHi = 65535;
  int lastErr = 0;

  localparam int NSAMP = 16;
  localparam int SAMP [NSAMP] = '{1200, 900, 30000, 1000, -20000, -15000, 500, 1100,
                                  800, 1000, 2000, -5000, 1500, 950, 1050, 1000};

  always #2 clk = ~clk;

  scan_zloop u_scan_zloop (
    .clk(clk), .rst_n(rst_n), .start(start), .heightMode(heightMode),
    .setpoint(setpoint), .kp(kp), .ki(ki), .zMin(zMin), .zMax(zMax),
    .gridX(gridX), .gridY(gridY), .dwell(dwell), .settleCycles(settleCycles),
    .sampleValid(sampleValid), .sampleIn(sampleIn), .posX(posX), .posY(posY),
    .zOut(zOut), .busy(busy), .recValid(recValid), .recX(recX), .recY(recY),
    .recZ(recZ), .recData(recData), .frameDone(frameDone)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Feedback law from R3, R4, R5
  task automatic modelStep(input int s);
    int e, acc, u;
    e = spM - s;
    acc = integM + kiM * e;
    if (acc > 524287) acc = 524287;
    if (acc < -524288) acc = -524288;
    integM = acc;
    u = (acc + kpM * e) >>> 4;
    if (u < zLo) u = zLo;
    else if (u > zHi) u = zHi;
    zM = u;
    lastErr = e;
  endtask

  task automatic sampleOnce(input int s);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = 16'(s);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 zOut", int'(zOut), 0);
    check("R1 recValid", int'(recValid), 0);
    check("R1 frameDone", int'(frameDone), 0);
    check("R1 pos", int'({posX, posY}), 0);
    rst_n = 1'b1;

    // Feedback frame walked from the sample table (R2 R3 R5 R6 R9 R10 R11)
    gridX = 8'd2; gridY = 8'd2; dwell = 8'd4;
    setpoint = 16'sd1000; kp = 8'd16; ki = 8'd4; zMin = 16'd100; zMax = 16'd3000;
    spM = 1000; kpM = 16; kiM = 4; zLo = 100; zHi = 3000;
    heightMode = 1'b0;
    pulseStart();
    setpoint = 16'sd5000;   // R10: ignored until next start
    heightMode = 1'b1;      // R10: ignored until next start
    for (int i = 0; i < NSAMP; i++) begin
      int px, py;
      px = (i / 4) % 2;
      py = i / 8;
      check("R2 posX", int'(posX), px);
      check("R2 posY", int'(posY), py);
      if (i == 5) begin
        pulseStart();       // R11: start while busy
        check("R11 posX kept", int'(posX), px);
      end
      sampleOnce(SAMP[i]);
      modelStep(SAMP[i]);
      check("R3 R5 R10 zOut", int'(zOut), zM);
      if (i % 4 == 3) begin
        check("R6 recValid", int'(recValid), 1);
        check("R6 recX", int'(recX), px);
        check("R6 recY", int'(recY), py);
        check("R6 recZ", int'(recZ), zM);
        check("R6 R10 recData", int'(recData), lastErr);
        check("R9 frameDone", int'(frameDone), (i == NSAMP - 1) ? 1 : 0);
        check("R9 busy", int'(busy), (i == NSAMP - 1) ? 0 : 1);
      end else begin
        check("R6 no record", int'(recValid), 0);
      end
    end
    @(negedge clk);
    check("R9 single pulse", int'(frameDone), 0);

    // R12: samples while idle
    sampleOnce(-30000);
    sampleOnce(30000);
    check("R12 zOut idle", int'(zOut), zM);
    check("R12 no record", int'(recValid), 0);

    // R4: integrator saturation
    gridX = 8'd1; gridY = 8'd1; dwell = 8'd3; heightMode = 1'b0;
    setpoint = 16'sd0; kp = 8'd0; ki = 8'd255; zMin = 16'd0; zMax = 16'hFFFF;
    spM = 0; kpM = 0; kiM = 255; zLo = 0; zHi = 65535;
    pulseStart();
    sampleOnce(-32768); modelStep(-32768);
    check("R4 positive limit", int'(zOut), 32767);
    sampleOnce(-32768); modelStep(-32768);
    check("R4 held at limit", int'(zOut), zM);
    sampleOnce(100); modelStep(100);
    check("R4 recovery", int'(zOut), zM);
    check("R4 record", int'(recZ), zM);

    // R7 R8: fixed-height frame with settling
    gridX = 8'd1; gridY = 8'd2; dwell = 8'd2; heightMode = 1'b1;
    settleCycles = 16'd5; kp = 8'd200; ki = 8'd200;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // edges 1..6 after start are settling; three strobes land inside it
    sampleValid = 1'b1; sampleIn = 16'sd7;
    repeat (3) @(negedge clk);
    sampleValid = 1'b0;
    check("R8 ignored at frame start", int'(recValid), 0);
    repeat (4) @(negedge clk);
    sampleOnce(1234);
    check("R8 first sample counted", int'(recValid), 0);
    sampleOnce(-777);
    check("R7 record", int'(recValid), 1);
    check("R7 recData raw", int'(recData), -777);
    check("R7 recZ held", int'(recZ), zM);
    check("R7 zOut held", int'(zOut), zM);
    check("R8 row advance", int'(posY), 1);
    sampleOnce(5); sampleOnce(6);
    check("R8 ignored after row", int'(recValid), 0);
    check("R8 still busy", int'(busy), 1);
    repeat (6) @(negedge clk);
    sampleOnce(-42);
    sampleOnce(4321);
    check("R7 second record", int'(recData), 4321);
    check("R7 recY", int'(recY), 1);
    check("R9 frame end", int'(frameDone), 1);
    check("R7 zOut unchanged", int'(zOut), zM);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule